// File: doc/BRIEF.md
# Double-Buffered Gate Control List Engine

This block sequences the transmit gates of one egress port from a list of gate commands. Each command pairs an interval, measured in transmit units (one unit per byte at gigabit speed, one per nibble at 10/100 speed), with an 8-bit open mask that has one bit per priority queue. The engine loads a command, drives its mask onto `gate_mask`, counts `tx_tick` pulses down to the end of the interval, and then moves to the next command. A cycle-start pulse from an external timer restarts the list at its first entry.

The command memory is split into two equal banks. Software fills the bank that is not in use and then points `bank_sel` at it. The engine switches banks only on the next cycle-start pulse and reports the bank it is running on `active_bank`. A single-bank mode pins the engine to bank 0. A command with a zero interval ends the list. Software normally places such a command last, with a mask that opens every queue the list never opened, so that any overrun past the cycle time still lets traffic out. While the engine is disabled, all gates stay open.

Top module: `gate_list_engine`

## Requirements
- R1: While `en` is low, `gate_mask` is 8'hFF, `cmd_ptr` is 0 and `list_done` is 0 from the edge after `en` is sampled low, and `cycle_start` has no effect on `active_bank` or any output.
- R2: A command word written through `wr_en`/`wr_addr`/`wr_data` holds the open mask in bits [7:0], where bit q opens queue q, and the interval count in bits [CNT_W+7:8]. The top address bit selects the bank and the lower bits select the entry.
- R3: Once enabled, the gates stay fully open until the first `cycle_start`. A `cycle_start` sampled with `en` high sets `cmd_ptr` to 0, and the mask of entry 0 of the selected bank appears on `gate_mask` two rising edges after the edge that samples the pulse.
- R4: A running command lasts for as many `tx_tick` pulses as its count, and any non-zero count below 16 counts as 16. The next entry's mask appears two edges after the edge that samples the final tick, and ticks during those two fetch cycles are not counted.
- R5: When the engine reaches an entry with a zero count, it drives that entry's mask, sets `list_done`, and holds both until the next `cycle_start`. Entries after the zero entry have no effect.
- R6: If the last entry of a bank expires without a zero entry, its mask is held and `list_done` is set until the next `cycle_start`.
- R7: A change of `bank_sel` takes effect only at the next `cycle_start`, and `active_bank` reports the bank in use. Until that pulse, the old bank's list keeps running.
- R8: A `cycle_start` that arrives before the list has finished restarts at entry 0 of the active bank, abandoning the current command.
- R9: With `single_bank` high, a `cycle_start` selects bank 0 regardless of `bank_sel`, and `active_bank` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| single_bank | input | 1 | Pin the engine to bank 0 |
| bank_sel | input | 1 | Bank to run from the next cycle start |
| cycle_start | input | 1 | One-cycle cycle-start pulse from the timer |
| tx_tick | input | 1 | One transmit unit (byte or nibble) sent |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | ADDR_W | Command address: {bank, entry} |
| wr_data | input | CNT_W+8 | Command word: {count, mask} |
| gate_mask | output | 8 | Per-queue gate open mask |
| active_bank | output | 1 | Bank currently in use |
| cmd_ptr | output | ADDR_W-1 | Entry currently in use |
| list_done | output | 1 | List ended; mask held until the next cycle start |

## Verification
The assertions check four things on every cycle: the open-gate state while disabled, the pointer reset on every cycle start, the pointer moving only forward by single steps, and `active_bank` changing only on a cycle-start pulse. They also check that a finished list holds its mask and that single-bank mode forces bank 0. Interval lengths, the 16-unit minimum, zero-count termination, holding of the last entry, and the fact that a bank switch is deferred while the old list keeps running can only be shown by the bench's scenarios. The bench compares each tick against a model of the written lists.

// File: rtl/gle_pkg.sv
package gle_pkg;
  localparam int MASK_W = 8;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ADDR,
    ST_LOAD,
    ST_RUN,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/gle_cmd_ram.sv
module gle_cmd_ram #(
  parameter int AW = 5,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Synchronous write and registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gle_interval_ctr.sv
module gle_interval_ctr #(
  parameter int CNT_W   = 10,
  parameter int MIN_CNT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] eff_val;

  // Short non-zero intervals are stretched to the minimum.
  always_comb begin
    if (load_val != '0 && load_val < CNT_W'(MIN_CNT)) eff_val = CNT_W'(MIN_CNT);
    else                                              eff_val = load_val;
  end

  assign expire = tick && (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                rem <= '0;
    else if (load)          rem <= eff_val;
    else if (tick && rem != '0) rem <= rem - 1'b1;
  end
endmodule

// File: rtl/gle_sequencer.sv
module gle_sequencer
  import gle_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              single_bank,
  input  logic              bank_sel,
  input  logic              cycle_start,
  input  logic              tx_tick,
  input  logic              rd_cnt_zero,
  input  logic [MASK_W-1:0] rd_mask,
  input  logic              expire,
  output logic              cnt_load,
  output logic              cnt_tick,
  output logic [PTR_W-1:0]  ptr,
  output logic              bank,
  output logic [MASK_W-1:0] mask,
  output logic              done
);
  localparam logic [PTR_W-1:0] LAST = {PTR_W{1'b1}};

  seq_state_e state;

  assign cnt_load = (state == ST_LOAD);
  assign cnt_tick = en && !cycle_start && (state == ST_RUN) && tx_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
      ptr   <= '0;
      bank  <= 1'b0;
      mask  <= '1;
      done  <= 1'b0;
    end else if (!en) begin
      state <= ST_OFF;
      ptr   <= '0;
      mask  <= '1;
      done  <= 1'b0;
    end else if (cycle_start) begin
      state <= ST_ADDR;
      ptr   <= '0;
      bank  <= single_bank ? 1'b0 : bank_sel;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: state <= ST_LOAD;
        ST_LOAD: begin
          mask <= rd_mask;
          if (rd_cnt_zero) begin
            state <= ST_HOLD;
            done  <= 1'b1;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (expire) begin
            if (ptr == LAST) begin
              state <= ST_HOLD;
              done  <= 1'b1;
            end else begin
              ptr   <= ptr + 1'b1;
              state <= ST_ADDR;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/gate_list_engine.sv
module gate_list_engine
  import gle_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 10,
  parameter int MIN_CNT = 16,
  localparam int PTR_W  = ADDR_W - 1,
  localparam int DW     = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              single_bank,
  input  logic              bank_sel,
  input  logic              cycle_start,
  input  logic              tx_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [7:0]        gate_mask,
  output logic              active_bank,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic              list_done
);
  logic [DW-1:0]    rd_word;
  logic [PTR_W-1:0] ptr;
  logic             bank;
  logic             cnt_load;
  logic             cnt_tick;
  logic             expire;

  gle_cmd_ram #(.AW(ADDR_W), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr ({bank, ptr}),
    .rdata (rd_word)
  );

  gle_interval_ctr #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (rd_word[DW-1:MASK_W]),
    .tick     (cnt_tick),
    .expire   (expire)
  );

  gle_sequencer #(.PTR_W(PTR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .single_bank (single_bank),
    .bank_sel    (bank_sel),
    .cycle_start (cycle_start),
    .tx_tick     (tx_tick),
    .rd_cnt_zero (rd_word[DW-1:MASK_W] == '0),
    .rd_mask     (rd_word[MASK_W-1:0]),
    .expire      (expire),
    .cnt_load    (cnt_load),
    .cnt_tick    (cnt_tick),
    .ptr         (ptr),
    .bank        (bank),
    .mask        (gate_mask),
    .done        (list_done)
  );

  assign active_bank = bank;
  assign cmd_ptr     = ptr;
endmodule

// File: rtl/gle_checker.sv
module gle_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             single_bank,
  input logic             cycle_start,
  input logic [7:0]       gate_mask,
  input logic             active_bank,
  input logic [PTR_W-1:0] cmd_ptr,
  input logic             list_done
);
  a_r1_disabled_open: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_mask == 8'hFF) && (cmd_ptr == '0) && !list_done);

  a_r3_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    (en && cycle_start) |=> (cmd_ptr == '0) && !list_done);

  a_r4_forward_step: assert property (@(posedge clk) disable iff (rst)
    (en && !cycle_start) |=> (cmd_ptr == $past(cmd_ptr)) ||
                             (cmd_ptr == PTR_W'($past(cmd_ptr) + 1'b1)));

  a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
    (list_done && en && !cycle_start) |=> list_done && $stable(gate_mask) && $stable(cmd_ptr));

  a_r7_bank_only_at_start: assert property (@(posedge clk) disable iff (rst)
    !(en && cycle_start) |=> $stable(active_bank));

  a_r9_single_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (en && cycle_start && single_bank) |=> !active_bank);
endmodule

bind gate_list_engine gle_checker #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .single_bank (single_bank),
  .cycle_start (cycle_start),
  .gate_mask   (gate_mask),
  .active_bank (active_bank),
  .cmd_ptr     (cmd_ptr),
  .list_done   (list_done)
);

// File: tb/tb_gate_list_engine.sv
`timescale 1ns/1ps
module tb_gate_list_engine;
  localparam int AW = 5, CW = 10, BD = 16, PW = 4, MINC = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, single_bank = 1'b0, bank_sel = 1'b0;
  logic cycle_start = 1'b0, tx_tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW+7:0] wr_data = '0;
  logic [7:0] gate_mask;
  logic active_bank, list_done;
  logic [PW-1:0] cmd_ptr;

  gate_list_engine #(.ADDR_W(AW), .CNT_W(CW), .MIN_CNT(MINC)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_cnt [2][BD];
  logic [7:0] m_msk [2][BD];

  // Expected {kind, mask} after n ticks: kind 0 running, 1 zero-ended, 2 bank-ended.
  function automatic logic [9:0] model(int b, int n);
    int used = n;
    for (int i = 0; i < BD; i++) begin
      int eff;
      if (m_cnt[b][i] == 0) return {2'd1, m_msk[b][i]};
      eff = (m_cnt[b][i] < MINC) ? MINC : m_cnt[b][i];
      if (used < eff) return {2'd0, m_msk[b][i]};
      used -= eff;
    end
    return {2'd2, m_msk[b][BD-1]};
  endfunction

  function automatic int total(int b);
    int s = 0;
    for (int i = 0; i < BD; i++) begin
      if (m_cnt[b][i] == 0) return s;
      s += (m_cnt[b][i] < MINC) ? MINC : m_cnt[b][i];
    end
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr_cmd(int b, int i, int c, logic [7:0] m);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = {b[0], i[PW-1:0]};
    wr_data = {c[CW-1:0], m};
    m_cnt[b][i] = c;
    m_msk[b][i] = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill(int b);
    int z = $urandom_range(0, BD);
    for (int i = 0; i < BD; i++)
      wr_cmd(b, i, (i == z) ? 0 : $urandom_range(1, 40), 8'($urandom));
  endtask

  task automatic pulse_cs();
    @(negedge clk); cycle_start = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
    cyc(3);
  endtask

  task automatic tick1();
    @(negedge clk); tx_tick = 1'b1;
    @(negedge clk); tx_tick = 1'b0;
    cyc(3);
  endtask

  task automatic check_state(int b, int n);
    logic [9:0] r = model(b, n);
    string tag = (r[9:8] == 2'd1) ? "R5" : (r[9:8] == 2'd2) ? "R6" : "R4";
    check(tag, gate_mask, r[7:0]);
    check(tag, list_done, (r[9:8] != 2'd0) ? 1 : 0);
  endtask

  task automatic start(int b);
    pulse_cs();
    check("R3 pointer at entry 0", cmd_ptr, 0);
    check("R7 active bank", active_bank, b);
    check_state(b, 0);
  endtask

  task automatic run(int b, int from, int to);
    for (int n = from + 1; n <= to; n++) begin
      tick1();
      check_state(b, n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst = 1'b0;
    cyc(2);
    // R1 reset / disabled state
    check("R1 mask", gate_mask, 8'hFF);
    check("R1 bank", active_bank, 0);
    check("R1 ptr", cmd_ptr, 0);
    check("R1 done", list_done, 0);

    // R3: enabled but no cycle start yet
    en = 1'b1;
    cyc(4);
    check("R3 open before start", gate_mask, 8'hFF);

    // Directed list in bank 0: clamp, zero terminator, trailing entries ignored
    wr_cmd(0, 0, 3, 8'h01);
    wr_cmd(0, 1, 20, 8'h02);
    wr_cmd(0, 2, 0, 8'hF0);
    for (int i = 3; i < BD; i++) wr_cmd(0, i, 25, 8'h55);
    start(0);
    check("R2 mask field", gate_mask, 8'h01);
    run(0, 0, 15);
    check("R4 clamp holds entry 0", gate_mask, 8'h01);
    run(0, 15, 16);
    check("R4 clamp advance", gate_mask, 8'h02);
    run(0, 16, 45);
    check("R5 terminator mask", gate_mask, 8'hF0);
    check("R5 done", list_done, 1);

    // R7: deferred bank switch
    fill(1);
    start(0);
    bank_sel = 1'b1;
    run(0, 0, 5);
    check("R7 bank held", active_bank, 0);
    start(1);
    run(1, 0, total(1) + 2);

    // R8: restart mid-list
    start(1);
    run(1, 0, 20);
    start(1);
    run(1, 0, 10);

    // R6: full bank without a zero entry
    for (int i = 0; i < BD; i++) wr_cmd(0, i, $urandom_range(1, 20), 8'($urandom));
    bank_sel = 1'b0;
    start(0);
    run(0, 0, total(0) + 3);
    check("R6 hold last", gate_mask, m_msk[0][BD-1]);

    // R9: single-bank mode ignores bank_sel
    single_bank = 1'b1;
    bank_sel = 1'b1;
    start(0);
    check("R9 active bank 0", active_bank, 0);
    run(0, 0, 30);
    single_bank = 1'b0;

    // R1: disable, then cycle start while disabled
    en = 1'b0;
    cyc(2);
    check("R1 disabled mask", gate_mask, 8'hFF);
    check("R1 disabled ptr", cmd_ptr, 0);
    check("R1 disabled done", list_done, 0);
    pulse_cs();
    check("R1 start ignored bank", active_bank, 0);
    check("R1 start ignored mask", gate_mask, 8'hFF);
    en = 1'b1;

    // Random lists on random banks
    for (int it = 0; it < 12; it++) begin
      int b = $urandom_range(0, 1);
      fill(b);
      bank_sel = b[0];
      start(b);
      run(b, 0, total(b) + 2);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule